// File: doc/BRIEF.md
# Processor exception entry controller

This block decides, cycle by cycle, whether the core takes an exception, a TLB-refill exception, a debug breakpoint or a hardware interrupt. When it takes one, it saves the mode and return state for that kind of entry, computes the handler address and issues a one-cycle redirect to the fetch unit. It owns a small set of control and status registers, and other parts of the core reach them through a flat select/read/write port.

Interrupt lines are sampled into a status field on every cycle. The two lowest status bits are set by software only. An interrupt is taken when global enable allows it, the debug state permits it, and at least one pending line is enabled in the local mask. Ordinary exceptions and interrupts use vectors spaced by a configurable stride from a common base. TLB refill uses its own entry address, and debug uses a fixed offset from the common base.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, the current-mode register reads 0x08: privilege 0 in bits [1:0], interrupt enable 0 in bit 2, direct-address 1 in bit 3, paging 0 in bit 4. The config register (enable mask in bits [12:0], stride in bits [18:16]) reads 0. The status interrupt bits read 0. `redirect_pc` is 0x1C000000 and `redirect_vld` is 0.
- R2: For each line i >= 2, status bit i follows `hw_irq[i]` one cycle later. `hw_irq[1:0]` are ignored. Status bits [1:0] change only through a write to the status register (select 2). That write leaves the cause field (bits [21:16]) and bits [12:2] unchanged.
- R3: An interrupt is taken only when interrupt enable is 1, the debug-state bit is 0, and (status AND enable mask) is nonzero.
- R4: Among the enabled pending lines, the highest-numbered line L wins. The target is base + (64 + L) * stride. The cause field is written with 0.
- R5: An ordinary exception writes its cause into the cause field and redirects to base + cause * stride.
- R6: On ordinary or interrupt entry, {enable, privilege} are saved into the previous-mode register (select 1: bit 2 enable, bits [1:0] privilege). The PC goes to the return register (select 4). Privilege and enable then become 0.
- R7: An exception request with `tlb_refill` set saves {enable, privilege} in the refill previous-mode register (select 7) and the PC in the refill return register (select 8). It sets direct-address to 1, clears paging, privilege and enable, redirects to the refill entry (select 6), and leaves the cause field and the ordinary save registers unchanged.
- R8: A debug breakpoint saves the PC in the debug return register (select 10). It sets the debug register (select 9) to code 0xC in bits [21:16], breakpoint bit 1 and debug-state bit 0. It redirects to base + 0x480 and leaves the current mode unchanged.
- R9: A fetch bus error uses cause 8 and a data bus error uses cause 9. Among synchronous requests in one cycle, the fetch error wins over the data error, and the data error wins over `exc_req`.
- R10: When requests coincide, the debug breakpoint wins over any synchronous request, and a synchronous request wins over an interrupt.
- R11: `redirect_vld` is high for exactly the one cycle after each entry edge, with the target on `redirect_pc`. No other cycle raises it.
- R12: Selects 0 to 10 read back what was written, in the field layouts above. Select 5 is the entry base and select 3 is the config register. A write in a cycle with no entry takes effect at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_irq | input | NIRQ | Interrupt line levels; bits [1:0] unused |
| exc_req | input | 1 | Synchronous exception request |
| exc_cause | input | ECODE_W | Cause code for `exc_req` |
| tlb_refill | input | 1 | Marks `exc_req` as a TLB refill |
| fetch_bus_err | input | 1 | Instruction fetch bus error |
| data_bus_err | input | 1 | Data access bus error |
| dbg_brk | input | 1 | Debug breakpoint request |
| cur_pc | input | AW | PC of the current instruction |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register select for read and write |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data for `reg_sel` |
| redirect_vld | output | 1 | One-cycle redirect pulse |
| redirect_pc | output | AW | Handler target address |

## Verification
The hardest situations to reach are the ones where several entry sources are live in the same cycle. The bench first sets the debug-state bit, so an enabled interrupt can be held pending without being taken. It then pulses a breakpoint together with an exception request. Next it clears the debug state in the cycle just before an exception request, so the exception and the interrupt compete on the same edge. Interrupt masking is shown with lines held high for several cycles while enable, mask or debug state blocks them. Any redirect that appears in those cycles counts as a miscompare.

// File: rtl/exc_entry_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the exception entry controller: register selects,
// field positions and fixed cause codes. Assumes 6-bit cause codes.
package exc_entry_pkg;
    typedef enum logic [3:0] {
        SEL_CUR    = 4'd0,
        SEL_PREV   = 4'd1,
        SEL_STAT   = 4'd2,
        SEL_CFG    = 4'd3,
        SEL_RET    = 4'd4,
        SEL_BASE   = 4'd5,
        SEL_RFBASE = 4'd6,
        SEL_RFPREV = 4'd7,
        SEL_RFRET  = 4'd8,
        SEL_DBG    = 4'd9,
        SEL_DBGRET = 4'd10
    } csr_sel_e;

    localparam int unsigned HI_FIELD_LSB = 16;
    localparam int unsigned DBG_CODE_W   = 6;
    localparam logic [5:0]  CAUSE_FETCH_ADDR = 6'd8;
    localparam logic [5:0]  CAUSE_MEM_ADDR   = 6'd9;
    localparam logic [5:0]  DBG_BRK_CODE     = 6'hC;
endpackage

// File: rtl/exc_irq_pick.sv
`timescale 1ns/1ps
// Highest-index priority picker over the enabled pending interrupt lines.
// Assumes N >= 2. Purely combinational.
module exc_irq_pick #(
    parameter int N  = 13,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          vld,
    output logic [IW-1:0] idx
);
    // Scan upward so the last (highest) set bit is the one that sticks.
    always_comb begin
        vld = |req;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/exc_vec_calc.sv
`timescale 1ns/1ps
// Vector address generator: base + index * stride. Assumes the product fits
// in AW bits; higher bits of the sum wrap.
module exc_vec_calc #(
    parameter int AW     = 32,
    parameter int VIDX_W = 7,
    parameter int VS_W   = 3
) (
    input  logic [AW-1:0]     base,
    input  logic [VIDX_W-1:0] vidx,
    input  logic [VS_W-1:0]   stride,
    output logic [AW-1:0]     target
);
    localparam int PW = VIDX_W + VS_W;
    logic [PW-1:0] offset;

    // Scale the vector index by the stride, then add to the base.
    always_comb begin
        offset = PW'(vidx) * PW'(stride);
        target = base + AW'(offset);
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
`timescale 1ns/1ps
// Exception entry controller. Arbitrates debug, synchronous and interrupt
// entry, updates the mode/status registers on the entry edge and issues a
// registered one-cycle redirect. Assumes AW >= 22 so the high fields fit.
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int              AW           = 32,
    parameter int              NIRQ         = 13,
    parameter int              SW_IRQ       = 2,
    parameter int              ECODE_W      = 6,
    parameter int              VS_W         = 3,
    parameter int              EXT_INT_BASE = 64,
    parameter logic [AW-1:0]   RESET_PC     = 'h1C00_0000,
    parameter logic [AW-1:0]   DBG_OFFSET   = 'h480
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NIRQ-1:0]    hw_irq,
    input  logic               exc_req,
    input  logic [ECODE_W-1:0] exc_cause,
    input  logic               tlb_refill,
    input  logic               fetch_bus_err,
    input  logic               data_bus_err,
    input  logic               dbg_brk,
    input  logic [AW-1:0]      cur_pc,
    input  logic               reg_wr_en,
    input  logic [3:0]         reg_sel,
    input  logic [AW-1:0]      reg_wdata,
    output logic [AW-1:0]      reg_rdata,
    output logic               redirect_vld,
    output logic [AW-1:0]      redirect_pc
);
    localparam int IRQ_IW  = $clog2(NIRQ);
    localparam int IRQ_MAXW = $clog2(EXT_INT_BASE + NIRQ);
    localparam int VIDX_W  = (ECODE_W > IRQ_MAXW) ? ECODE_W : IRQ_MAXW;

    // Architectural state
    logic [1:0]            plv_q, pplv_q, rf_pplv_q;
    logic                  ie_q, da_q, pg_q, pie_q, rf_pie_q;
    logic [NIRQ-1:0]       is_q, lie_q;
    logic [ECODE_W-1:0]    ecode_q;
    logic [VS_W-1:0]       vs_q;
    logic [AW-1:0]         era_q, eentry_q, rf_entry_q, rf_era_q, dbg_era_q;
    logic                  dst_q, dbg_bp_q;
    logic [DBG_CODE_W-1:0] dbg_code_q;

    // Arbitration signals
    logic [NIRQ-1:0]    pend;
    logic               pick_vld;
    logic [IRQ_IW-1:0]  pick_idx;
    logic               sync_req, irq_ok;
    logic               take_dbg, take_sync, take_irq, take_refill, take_ord, take_any;
    logic [ECODE_W-1:0] sync_cause, new_ecode;
    logic [VIDX_W-1:0]  vidx;
    logic [AW-1:0]      ord_target, target;

    assign pend = is_q & lie_q;

    exc_irq_pick #(.N(NIRQ), .IW(IRQ_IW)) u_pick (
        .req (pend),
        .vld (pick_vld),
        .idx (pick_idx)
    );

    // Entry arbitration: debug, then synchronous, then interrupt.
    always_comb begin
        sync_req    = fetch_bus_err | data_bus_err | exc_req;
        irq_ok      = ie_q & ~dst_q & pick_vld;
        take_dbg    = dbg_brk;
        take_sync   = ~dbg_brk & sync_req;
        take_irq    = ~dbg_brk & ~sync_req & irq_ok;
        take_refill = take_sync & ~fetch_bus_err & ~data_bus_err & tlb_refill;
        take_ord    = (take_sync & ~take_refill) | take_irq;
        take_any    = take_dbg | take_sync | take_irq;
        if (fetch_bus_err)     sync_cause = ECODE_W'(CAUSE_FETCH_ADDR);
        else if (data_bus_err) sync_cause = ECODE_W'(CAUSE_MEM_ADDR);
        else                   sync_cause = exc_cause;
        new_ecode = take_irq ? '0 : sync_cause;
        vidx = take_irq ? (VIDX_W'(EXT_INT_BASE) + VIDX_W'(pick_idx))
                        : VIDX_W'(sync_cause);
    end

    exc_vec_calc #(.AW(AW), .VIDX_W(VIDX_W), .VS_W(VS_W)) u_vec (
        .base   (eentry_q),
        .vidx   (vidx),
        .stride (vs_q),
        .target (ord_target)
    );

    // Final target selection per entry path.
    always_comb begin
        if (take_dbg)         target = eentry_q + DBG_OFFSET;
        else if (take_refill) target = rf_entry_q;
        else                  target = ord_target;
    end

    // Register update: entry paths first, software writes otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            plv_q <= '0; ie_q <= 1'b0; da_q <= 1'b1; pg_q <= 1'b0;
            pplv_q <= '0; pie_q <= 1'b0; rf_pplv_q <= '0; rf_pie_q <= 1'b0;
            is_q <= '0; lie_q <= '0; vs_q <= '0; ecode_q <= '0;
            era_q <= '0; eentry_q <= '0; rf_entry_q <= '0; rf_era_q <= '0;
            dbg_era_q <= '0; dst_q <= 1'b0; dbg_bp_q <= 1'b0; dbg_code_q <= '0;
        end else begin
            for (int i = SW_IRQ; i < NIRQ; i++) is_q[i] <= hw_irq[i];
            if (take_dbg) begin
                dbg_era_q  <= cur_pc;
                dst_q      <= 1'b1;
                dbg_bp_q   <= 1'b1;
                dbg_code_q <= DBG_BRK_CODE;
            end else if (take_refill) begin
                rf_pplv_q <= plv_q;
                rf_pie_q  <= ie_q;
                rf_era_q  <= cur_pc;
                da_q      <= 1'b1;
                pg_q      <= 1'b0;
                plv_q     <= '0;
                ie_q      <= 1'b0;
            end else if (take_ord) begin
                pplv_q  <= plv_q;
                pie_q   <= ie_q;
                era_q   <= cur_pc;
                ecode_q <= new_ecode;
                plv_q   <= '0;
                ie_q    <= 1'b0;
            end else if (reg_wr_en) begin
                case (csr_sel_e'(reg_sel))
                    SEL_CUR: begin
                        plv_q <= reg_wdata[1:0]; ie_q <= reg_wdata[2];
                        da_q  <= reg_wdata[3];   pg_q <= reg_wdata[4];
                    end
                    SEL_PREV:   begin pplv_q <= reg_wdata[1:0]; pie_q <= reg_wdata[2]; end
                    SEL_STAT:   is_q[SW_IRQ-1:0] <= reg_wdata[SW_IRQ-1:0];
                    SEL_CFG: begin
                        lie_q <= reg_wdata[NIRQ-1:0];
                        vs_q  <= reg_wdata[HI_FIELD_LSB +: VS_W];
                    end
                    SEL_RET:    era_q      <= reg_wdata;
                    SEL_BASE:   eentry_q   <= reg_wdata;
                    SEL_RFBASE: rf_entry_q <= reg_wdata;
                    SEL_RFPREV: begin rf_pplv_q <= reg_wdata[1:0]; rf_pie_q <= reg_wdata[2]; end
                    SEL_RFRET:  rf_era_q   <= reg_wdata;
                    SEL_DBG: begin
                        dst_q      <= reg_wdata[0];
                        dbg_bp_q   <= reg_wdata[1];
                        dbg_code_q <= reg_wdata[HI_FIELD_LSB +: DBG_CODE_W];
                    end
                    SEL_DBGRET: dbg_era_q  <= reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    // Redirect output: one registered pulse per entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_vld <= 1'b0;
            redirect_pc  <= RESET_PC;
        end else begin
            redirect_vld <= take_any;
            if (take_any) redirect_pc <= target;
        end
    end

    // Register read mux in the documented field layouts.
    always_comb begin
        reg_rdata = '0;
        case (csr_sel_e'(reg_sel))
            SEL_CUR:    reg_rdata[4:0] = {pg_q, da_q, ie_q, plv_q};
            SEL_PREV:   reg_rdata[2:0] = {pie_q, pplv_q};
            SEL_STAT: begin
                reg_rdata[NIRQ-1:0]                 = is_q;
                reg_rdata[HI_FIELD_LSB +: ECODE_W]  = ecode_q;
            end
            SEL_CFG: begin
                reg_rdata[NIRQ-1:0]                 = lie_q;
                reg_rdata[HI_FIELD_LSB +: VS_W]     = vs_q;
            end
            SEL_RET:    reg_rdata = era_q;
            SEL_BASE:   reg_rdata = eentry_q;
            SEL_RFBASE: reg_rdata = rf_entry_q;
            SEL_RFPREV: reg_rdata[2:0] = {rf_pie_q, rf_pplv_q};
            SEL_RFRET:  reg_rdata = rf_era_q;
            SEL_DBG: begin
                reg_rdata[1:0]                         = {dbg_bp_q, dst_q};
                reg_rdata[HI_FIELD_LSB +: DBG_CODE_W]  = dbg_code_q;
            end
            SEL_DBGRET: reg_rdata = dbg_era_q;
            default:    reg_rdata = '0;
        endcase
    end

    // R4
    pick_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pick_vld |-> ((pend >> pick_idx) == NIRQ'(1)));
    // R6
    ord_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_ord |=> (plv_q == 2'd0 && !ie_q && era_q == $past(cur_pc)));
    // R7
    refill_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_refill |=> (da_q && !pg_q && rf_pie_q == $past(ie_q) && redirect_pc == $past(rf_entry_q)));
    // R8
    dbg_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_dbg |=> (dst_q && dbg_era_q == $past(cur_pc)));
    // R10
    dbg_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_brk |=> (redirect_pc == $past(eentry_q) + DBG_OFFSET));
    // R11
    redirect_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_any |=> redirect_vld);
    // R11
    redirect_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take_any |=> !redirect_vld);
endmodule

// File: tb/exc_entry_ctrl_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: stimulus tasks queue expected redirect targets and a
// monitor compares each redirect pulse with the head of the queue.
module exc_entry_ctrl_bench;
    localparam int AW = 32;
    localparam int NIRQ = 13;
    localparam logic [31:0] BASE = 32'h8000_0000;
    localparam logic [31:0] RFB  = 32'h9000_0000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NIRQ-1:0] hw_irq = '0;
    logic            exc_req = 1'b0;
    logic [5:0]      exc_cause = '0;
    logic            tlb_refill = 1'b0;
    logic            fetch_bus_err = 1'b0;
    logic            data_bus_err = 1'b0;
    logic            dbg_brk = 1'b0;
    logic [AW-1:0]   cur_pc = '0;
    logic            reg_wr_en = 1'b0;
    logic [3:0]      reg_sel = '0;
    logic [AW-1:0]   reg_wdata = '0;
    logic [AW-1:0]   reg_rdata;
    logic            redirect_vld;
    logic [AW-1:0]   redirect_pc;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    exc_entry_ctrl u_exc_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .hw_irq(hw_irq), .exc_req(exc_req),
        .exc_cause(exc_cause), .tlb_refill(tlb_refill),
        .fetch_bus_err(fetch_bus_err), .data_bus_err(data_bus_err),
        .dbg_brk(dbg_brk), .cur_pc(cur_pc), .reg_wr_en(reg_wr_en),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .redirect_vld(redirect_vld), .redirect_pc(redirect_pc)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Monitor: pop and compare on each redirect pulse.
    always @(negedge clk) begin
        if (rst_n && !done && redirect_vld) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected redirect", redirect_pc, 32'hFFFF_FFFF);
            end else begin
                check(tag_q.pop_front(), redirect_pc, exp_q.pop_front());
            end
        end
    end

    task automatic expect_redirect(logic [31:0] pc, string tag);
        exp_q.push_back(pc);
        tag_q.push_back(tag);
    endtask

    task automatic wr(logic [3:0] sel, logic [31:0] data);
        reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(logic [3:0] sel, logic [31:0] mask, logic [31:0] exp, string tag);
        reg_sel = sel;
        #1;
        check(tag, reg_rdata & mask, exp);
    endtask

    task automatic pulse(logic e, logic rf, logic fe, logic de, logic db,
                         logic [5:0] cause, logic [31:0] pc);
        exc_req = e; tlb_refill = rf; fetch_bus_err = fe; data_bus_err = de;
        dbg_brk = db; exc_cause = cause; cur_pc = pc;
        @(negedge clk);
        exc_req = 0; tlb_refill = 0; fetch_bus_err = 0; data_bus_err = 0; dbg_brk = 0;
    endtask

    task automatic quiet(int n, string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(tag, {31'd0, redirect_vld}, 32'd0);
        end
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 redirect_pc", redirect_pc, 32'h1C00_0000);
        check("R1 redirect_vld", {31'd0, redirect_vld}, 32'd0);
        rd(4'd0, 32'hFFFF_FFFF, 32'h08, "R1 current mode");
        rd(4'd3, 32'hFFFF_FFFF, 32'h0, "R1 config");
        rd(4'd2, 32'h1FFF, 32'h0, "R1 status bits");

        // R12 setup and read back
        wr(4'd5, BASE);
        wr(4'd6, RFB);
        wr(4'd3, (32'd4 << 16));
        wr(4'd0, 32'h0F);
        rd(4'd5, 32'hFFFF_FFFF, BASE, "R12 base");
        rd(4'd3, 32'hFFFF_FFFF, 32'h0004_0000, "R12 config");

        // R5 / R6 ordinary exception
        expect_redirect(BASE + 5 * 4, "R5 ordinary target");
        pulse(1, 0, 0, 0, 0, 6'd5, 32'h0000_1000);
        @(negedge clk);
        rd(4'd2, 32'h003F_0000, 32'h0005_0000, "R5 cause field");
        rd(4'd1, 32'hFFFF_FFFF, 32'h7, "R6 previous mode");
        rd(4'd4, 32'hFFFF_FFFF, 32'h0000_1000, "R6 return address");
        rd(4'd0, 32'hFFFF_FFFF, 32'h08, "R6 mode cleared");

        // R7 refill entry
        wr(4'd0, 32'h16);
        expect_redirect(RFB, "R7 refill target");
        pulse(1, 1, 0, 0, 0, 6'd3, 32'h0000_1234);
        @(negedge clk);
        rd(4'd7, 32'hFFFF_FFFF, 32'h6, "R7 refill previous mode");
        rd(4'd8, 32'hFFFF_FFFF, 32'h0000_1234, "R7 refill return");
        rd(4'd0, 32'hFFFF_FFFF, 32'h08, "R7 mode after refill");
        rd(4'd1, 32'hFFFF_FFFF, 32'h7, "R7 ordinary save untouched");
        rd(4'd2, 32'h003F_0000, 32'h0005_0000, "R7 cause untouched");

        // R9 bus errors and their order
        expect_redirect(BASE + 8 * 4, "R9 fetch error target");
        pulse(0, 0, 1, 1, 0, 6'd0, 32'h0000_2000);
        expect_redirect(BASE + 9 * 4, "R9 data error target");
        pulse(1, 0, 0, 1, 0, 6'd3, 32'h0000_2004);
        @(negedge clk);
        rd(4'd2, 32'h003F_0000, 32'h0009_0000, "R9 data error cause");

        // R3 gating: mask excludes the line
        hw_irq = 13'h080;
        wr(4'd3, (32'd4 << 16) | 32'h008);
        wr(4'd0, 32'h0C);
        quiet(4, "R3 masked line");
        rd(4'd2, 32'h1FFF, 32'h080, "R2 line follows level");
        // R3 gating: enable off
        wr(4'd0, 32'h08);
        hw_irq = 13'h088;
        wr(4'd3, (32'd4 << 16) | 32'h088);
        quiet(4, "R3 enable off");
        // R3 gating: debug state set
        wr(4'd9, 32'h1);
        wr(4'd0, 32'h0C);
        quiet(4, "R3 debug state");
        // R4 highest line wins once debug state clears
        expect_redirect(BASE + (64 + 7) * 4, "R4 interrupt target");
        wr(4'd9, 32'h0);
        repeat (3) @(negedge clk);
        rd(4'd0, 32'hFFFF_FFFF, 32'h08, "R6 mode after interrupt");
        rd(4'd1, 32'hFFFF_FFFF, 32'h4, "R6 previous mode after interrupt");
        rd(4'd2, 32'h003F_1FFF, 32'h0000_0088, "R4 cause zero and status");

        // R2 software bits
        hw_irq = 13'h003;
        repeat (2) @(negedge clk);
        rd(4'd2, 32'h1FFF, 32'h0, "R2 low lines ignored");
        wr(4'd2, 32'h003F_1FFF);
        rd(4'd2, 32'h003F_1FFF, 32'h3, "R2 software write");
        wr(4'd3, (32'd4 << 16) | 32'h003);
        expect_redirect(BASE + (64 + 1) * 4, "R4 software line target");
        wr(4'd0, 32'h0C);
        repeat (2) @(negedge clk);
        wr(4'd2, 32'h0);
        hw_irq = 13'h000;

        // R8 / R10 debug over exception while an interrupt is held off
        wr(4'd9, 32'h1);
        hw_irq = 13'h020;
        wr(4'd3, (32'd4 << 16) | 32'h020);
        wr(4'd0, 32'h0C);
        expect_redirect(BASE + 32'h480, "R10 debug first");
        pulse(1, 0, 0, 0, 1, 6'd6, 32'h5555_0000);
        @(negedge clk);
        rd(4'd9, 32'hFFFF_FFFF, 32'h000C_0003, "R8 debug register");
        rd(4'd10, 32'hFFFF_FFFF, 32'h5555_0000, "R8 debug return");
        rd(4'd0, 32'hFFFF_FFFF, 32'h0C, "R8 mode unchanged");
        // R10 exception over interrupt on the same edge
        wr(4'd9, 32'h0);
        expect_redirect(BASE + 6 * 4, "R10 exception over interrupt");
        pulse(1, 0, 0, 0, 0, 6'd6, 32'h5555_0004);
        quiet(3, "R10 no interrupt after entry");
        hw_irq = 13'h000;

        // R5 zero stride
        wr(4'd3, 32'h0);
        expect_redirect(BASE, "R5 zero stride target");
        pulse(1, 0, 0, 0, 0, 6'd7, 32'h0000_3000);
        repeat (3) @(negedge clk);
        check("R11 all expected redirects seen", exp_q.size(), 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule